// File: doc/BRIEF.md
# Flash Program/Erase Control Interlock

This block sits between a CPU register bus and a flash cell array and guards the high-voltage path used to program or erase cells. Software arms address capture by setting a capture-arm bit in a small control register. The next write to a valid array word is then held as the target address and data for the coming operation. It is not passed to the array as a normal write.

Only after such a pair has been captured will the block let software set the high-voltage enable bit, and that bit drives the high-voltage output directly. While high voltage is on, the arm bit and the erase-select bit are frozen. Writes that try to clear the arm bit or flip the erase bit have no effect on them. The enable bit itself may still be cleared. Pulse counts, pulse widths and verify delays are all timed by software. The block only enforces the ordering.

Control register layout, used for both write and read: bit 0 is the high-voltage enable, bit 1 is the capture-arm bit, bit 2 is erase-select, and bit 3 is the captured flag (read only; write data in that position is ignored). Bits 7:4 read as zero.

Top module: `fpe_interlock`

## Requirements
- R1: Reset clears the arm, erase-select, high-voltage enable and captured bits, so the readback is 0x00 and `hv_enable` is low. The captured address and data read as zero.
- R2: While the arm bit (bit 1) is clear, an array write is passed through in the same cycle on `norm_wr_en`/`norm_addr`/`norm_wdata` and nothing is captured.
- R3: While the arm bit is set and nothing is captured, the first array write to an address below `ARRAY_WORDS` is captured. From the next cycle, readback bit 3 is set and `cap_addr`/`cap_wdata` hold that write.
- R4: While armed, an array write to an address at or above `ARRAY_WORDS` is neither captured nor passed through.
- R5: A register write that sets bit 0 leaves the enable clear unless, before the write, the arm bit was set and a pair was captured, and the write itself keeps bit 1 set.
- R6: When R5's conditions hold, a write with bit 0 set raises readback bit 0 and `hv_enable` in the next cycle. This works in both program mode (bit 2 clear) and erase mode (bit 2 set).
- R7: While the enable is set, a register write with bit 1 clear leaves the arm bit set.
- R8: While the enable is set, a register write that changes bit 2 leaves the erase-select bit unchanged.
- R9: While armed with a pair captured, further array writes neither replace the captured pair nor pass through.
- R10: With the enable clear, a register write with bit 1 clear discards the capture. The captured flag and the captured address and data return to zero, and the next array write is a normal access.
- R11: A register write with bit 0 clear drops `hv_enable` in the next cycle. After that, bit 2 may be changed again.
- R12: `hv_enable` always equals readback bit 0.
- R13: If one cycle carries both an array write that would be captured and a register write that clears the arm bit, the discard wins and nothing stays captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register readback |
| arr_wr_en | input | 1 | Array write strobe from the CPU |
| arr_addr | input | AW (8) | Array write word address |
| arr_wdata | input | DW (16) | Array write data |
| norm_wr_en | output | 1 | Normal write forwarded to the array |
| norm_addr | output | AW (8) | Forwarded address |
| norm_wdata | output | DW (16) | Forwarded data |
| cap_addr | output | AW (8) | Captured target address |
| cap_wdata | output | DW (16) | Captured target data |
| hv_enable | output | 1 | Program/erase high-voltage enable |

## Verification
Pass-through of a normal array write is combinational, so it is checked in the same cycle as the stimulus, one nanosecond after the inputs change on the falling edge. Every register effect passes through exactly one flop: the arm, erase, enable and captured bits, the captured pair and `hv_enable`. These are therefore sampled on the falling edge after the rising edge that takes the stimulus. Each table row drives one operation, checks the forwarding outputs before that edge and checks the readback, the captured pair and `hv_enable` half a cycle after it. The directed tests for the same-cycle conflict and reset follow the same timing.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
    localparam int REG_W   = 8;
    localparam int BIT_HV  = 0;
    localparam int BIT_LAT = 1;
    localparam int BIT_ERS = 2;
    localparam int BIT_CAP = 3;

    typedef struct packed {
        logic cap;
        logic ers;
        logic lat;
        logic hv;
    } ctl_t;
endpackage

// File: rtl/fpe_wr_route.sv
module fpe_wr_route #(
    parameter int AW          = 8,
    parameter int ARRAY_WORDS = 200
) (
    input  logic          arr_wr_en,
    input  logic [AW-1:0] arr_addr,
    input  fpe_pkg::ctl_t ctl_q,
    output logic          cap_fire,
    output logic          norm_wr
);
    localparam logic [AW:0] LIMIT = (AW+1)'(ARRAY_WORDS);

    logic addr_ok;

    always_comb begin
        addr_ok  = ({1'b0, arr_addr} < LIMIT);
        cap_fire = arr_wr_en & ctl_q.lat & ~ctl_q.cap & ~ctl_q.hv & addr_ok;
        norm_wr  = arr_wr_en & ~ctl_q.lat;
    end
endmodule

// File: rtl/fpe_ctrl_reg.sv
module fpe_ctrl_reg
    import fpe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             cap_fire,
    output ctl_t             ctl_q,
    output logic             discard
);
    ctl_t ctl_d;
    ctl_t ctl_r;

    always_comb begin
        ctl_d   = ctl_r;
        discard = 1'b0;
        if (cap_fire) begin
            ctl_d.cap = 1'b1;
        end
        if (reg_wr_en) begin
            if (ctl_r.hv) begin
                // arm and mode frozen while high voltage is on
                ctl_d.hv = reg_wdata[BIT_HV];
            end else begin
                ctl_d.lat = reg_wdata[BIT_LAT];
                ctl_d.ers = reg_wdata[BIT_ERS];
                ctl_d.hv  = reg_wdata[BIT_HV] & reg_wdata[BIT_LAT]
                          & ctl_r.lat & ctl_r.cap;
                if (!reg_wdata[BIT_LAT]) begin
                    ctl_d.cap = 1'b0;
                    discard   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_r <= '0;
        end else begin
            ctl_r <= ctl_d;
        end
    end

    assign ctl_q = ctl_r;
endmodule

// File: rtl/fpe_capture.sv
module fpe_capture #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_fire,
    input  logic          discard,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);
    logic [AW-1:0] addr_d;
    logic [DW-1:0] data_d;

    always_comb begin
        addr_d = addr_q;
        data_d = data_q;
        if (discard) begin
            addr_d = '0;
            data_d = '0;
        end else if (cap_fire) begin
            addr_d = addr_in;
            data_d = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            addr_q <= addr_d;
            data_q <= data_d;
        end
    end
endmodule

// File: rtl/fpe_interlock.sv
module fpe_interlock
    import fpe_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 16,
    parameter int ARRAY_WORDS = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             arr_wr_en,
    input  logic [AW-1:0]    arr_addr,
    input  logic [DW-1:0]    arr_wdata,
    output logic             norm_wr_en,
    output logic [AW-1:0]    norm_addr,
    output logic [DW-1:0]    norm_wdata,
    output logic [AW-1:0]    cap_addr,
    output logic [DW-1:0]    cap_wdata,
    output logic             hv_enable
);
    ctl_t ctl_q;
    logic cap_fire;
    logic discard;

    fpe_wr_route #(.AW(AW), .ARRAY_WORDS(ARRAY_WORDS)) u_route (
        .arr_wr_en (arr_wr_en),
        .arr_addr  (arr_addr),
        .ctl_q     (ctl_q),
        .cap_fire  (cap_fire),
        .norm_wr   (norm_wr_en)
    );

    fpe_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .cap_fire  (cap_fire),
        .ctl_q     (ctl_q),
        .discard   (discard)
    );

    fpe_capture #(.AW(AW), .DW(DW)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_fire (cap_fire),
        .discard  (discard),
        .addr_in  (arr_addr),
        .data_in  (arr_wdata),
        .addr_q   (cap_addr),
        .data_q   (cap_wdata)
    );

    always_comb begin
        reg_rdata          = '0;
        reg_rdata[BIT_HV]  = ctl_q.hv;
        reg_rdata[BIT_LAT] = ctl_q.lat;
        reg_rdata[BIT_ERS] = ctl_q.ers;
        reg_rdata[BIT_CAP] = ctl_q.cap;
        norm_addr          = arr_addr;
        norm_wdata         = arr_wdata;
        hv_enable          = ctl_q.hv;
    end
endmodule

// File: rtl/fpe_interlock_chk.sv
module fpe_interlock_chk #(
    parameter int AW          = 8,
    parameter int DW          = 16,
    parameter int ARRAY_WORDS = 200
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr_en,
    input logic [7:0]    reg_rdata,
    input logic          arr_wr_en,
    input logic [AW-1:0] arr_addr,
    input logic          norm_wr_en,
    input logic [AW-1:0] norm_addr,
    input logic [AW-1:0] cap_addr,
    input logic [DW-1:0] cap_wdata,
    input logic          hv_enable
);
    localparam logic [AW:0] LIMIT = (AW+1)'(ARRAY_WORDS);

    p_hv_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hv_enable) |-> $past(reg_rdata[1] && reg_rdata[3]));

    p_lat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hv_enable) |-> reg_rdata[1]);

    p_ers_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hv_enable) |-> $stable(reg_rdata[2]));

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_en && reg_rdata[1] && !reg_rdata[3] && !hv_enable
         && ({1'b0, arr_addr} < LIMIT) && !reg_wr_en)
        |=> (reg_rdata[3] && cap_addr == $past(arr_addr)));

    p_norm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_en && !reg_rdata[1]) |-> (norm_wr_en && norm_addr == arr_addr));

    p_nopass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[1] |-> !norm_wr_en);

    p_cap_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_rdata[3]) && reg_rdata[3]) |-> ($stable(cap_addr) && $stable(cap_wdata)));
endmodule

bind fpe_interlock fpe_interlock_chk #(.AW(AW), .DW(DW), .ARRAY_WORDS(ARRAY_WORDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_rdata  (reg_rdata),
    .arr_wr_en  (arr_wr_en),
    .arr_addr   (arr_addr),
    .norm_wr_en (norm_wr_en),
    .norm_addr  (norm_addr),
    .cap_addr   (cap_addr),
    .cap_wdata  (cap_wdata),
    .hv_enable  (hv_enable)
);

// File: tb/fpe_interlock_tb.sv
module fpe_interlock_tb;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NV = 19;
    localparam logic [1:0] OREG = 2'd1;
    localparam logic [1:0] OARR = 2'd2;

    // op, reg data, addr, data, exp norm, exp rdata, exp cap addr, exp cap data
    localparam logic [66:0] VEC [0:NV-1] = '{
        {OREG, 8'h00, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 16'h0000}, // R1
        {OARR, 8'h00, 8'h10, 16'h1234, 1'b1, 8'h00, 8'h00, 16'h0000}, // R2
        {OREG, 8'h01, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 16'h0000}, // R5
        {OREG, 8'h02, 8'h00, 16'h0000, 1'b0, 8'h02, 8'h00, 16'h0000}, // arm
        {OREG, 8'h03, 8'h00, 16'h0000, 1'b0, 8'h02, 8'h00, 16'h0000}, // R5
        {OARR, 8'h00, 8'hC8, 16'h7777, 1'b0, 8'h02, 8'h00, 16'h0000}, // R4
        {OARR, 8'h00, 8'h20, 16'hABCD, 1'b0, 8'h0A, 8'h20, 16'hABCD}, // R3
        {OARR, 8'h00, 8'h30, 16'h5555, 1'b0, 8'h0A, 8'h20, 16'hABCD}, // R9
        {OREG, 8'h03, 8'h00, 16'h0000, 1'b0, 8'h0B, 8'h20, 16'hABCD}, // R6
        {OREG, 8'h01, 8'h00, 16'h0000, 1'b0, 8'h0B, 8'h20, 16'hABCD}, // R7
        {OREG, 8'h07, 8'h00, 16'h0000, 1'b0, 8'h0B, 8'h20, 16'hABCD}, // R8
        {OARR, 8'h00, 8'h40, 16'h9999, 1'b0, 8'h0B, 8'h20, 16'hABCD}, // R9
        {OREG, 8'h02, 8'h00, 16'h0000, 1'b0, 8'h0A, 8'h20, 16'hABCD}, // R11
        {OREG, 8'h06, 8'h00, 16'h0000, 1'b0, 8'h0E, 8'h20, 16'hABCD}, // R11
        {OREG, 8'h07, 8'h00, 16'h0000, 1'b0, 8'h0F, 8'h20, 16'hABCD}, // R6
        {OREG, 8'h03, 8'h00, 16'h0000, 1'b0, 8'h0F, 8'h20, 16'hABCD}, // R8
        {OREG, 8'h06, 8'h00, 16'h0000, 1'b0, 8'h0E, 8'h20, 16'hABCD}, // R11
        {OREG, 8'h00, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, 16'h0000}, // R10
        {OARR, 8'h00, 8'h50, 16'h4242, 1'b1, 8'h00, 8'h00, 16'h0000}  // R10
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          arr_wr_en = 1'b0;
    logic [AW-1:0] arr_addr = '0;
    logic [DW-1:0] arr_wdata = '0;
    logic          norm_wr_en;
    logic [AW-1:0] norm_addr;
    logic [DW-1:0] norm_wdata;
    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cap_wdata;
    logic          hv_enable;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    fpe_interlock u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .arr_wr_en(arr_wr_en), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .norm_wr_en(norm_wr_en), .norm_addr(norm_addr),
        .norm_wdata(norm_wdata), .cap_addr(cap_addr), .cap_wdata(cap_wdata),
        .hv_enable(hv_enable)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset rdata", 32'(reg_rdata), 32'h0);
        check("R1 reset hv", 32'(hv_enable), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            reg_wr_en = (VEC[i][66:65] == OREG);
            arr_wr_en = (VEC[i][66:65] == OARR);
            reg_wdata = VEC[i][64:57];
            arr_addr  = VEC[i][56:49];
            arr_wdata = VEC[i][48:33];
            #1;
            check($sformatf("R2/R4/R9 norm row %0d", i), 32'(norm_wr_en), 32'(VEC[i][32]));
            if (norm_wr_en)
                check($sformatf("R2 norm data row %0d", i), {norm_addr, norm_wdata},
                      {VEC[i][56:49], VEC[i][48:33]});
            @(negedge clk);
            reg_wr_en = 1'b0;
            arr_wr_en = 1'b0;
            check($sformatf("rdata row %0d", i), 32'(reg_rdata), 32'(VEC[i][31:24]));
            check($sformatf("R12 hv row %0d", i), 32'(hv_enable), 32'(VEC[i][24]));
            check($sformatf("R3/R9/R10 cap row %0d", i), {cap_addr, cap_wdata},
                  {VEC[i][23:16], VEC[i][15:0]});
        end

        // R13: capture and discard in the same cycle
        reg_wr_en = 1'b1; reg_wdata = 8'h02;
        @(negedge clk);
        reg_wdata = 8'h00; arr_wr_en = 1'b1; arr_addr = 8'h11; arr_wdata = 16'h3C3C;
        @(negedge clk);
        reg_wr_en = 1'b0; arr_wr_en = 1'b0;
        check("R13 rdata", 32'(reg_rdata), 32'h0);
        check("R13 cap", {cap_addr, cap_wdata}, 32'h0);

        // R1: reset while high voltage is on
        reg_wr_en = 1'b1; reg_wdata = 8'h06;
        @(negedge clk);
        reg_wr_en = 1'b0; arr_wr_en = 1'b1; arr_addr = 8'hC7; arr_wdata = 16'h0F0F;
        @(negedge clk);
        arr_wr_en = 1'b0;
        check("R3 edge addr rdata", 32'(reg_rdata), 32'h0E);
        reg_wr_en = 1'b1; reg_wdata = 8'h07;
        @(negedge clk);
        reg_wr_en = 1'b0;
        check("R6 erase hv", 32'(hv_enable), 32'h1);
        rst_n = 1'b0;
        #1;
        check("R1 reset rdata", 32'(reg_rdata), 32'h0);
        check("R1 reset hv", 32'(hv_enable), 32'h0);
        check("R1 reset cap", {cap_addr, cap_wdata}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule